// File: doc/BRIEF.md
# Serial Grant Chain Node

This block is the per-device logic that sits on one priority level of a grant line wired in series from device to device. A grant enters from the upstream neighbour, or from the arbiter for the first device. The node either keeps the grant for its own device or hands it on to the next device down the line. A node keeps a grant only if its device already had a request pending when the grant arrived. Devices nearer the arbiter therefore see each grant first and win over devices further down.

A node that keeps a grant raises a selection acknowledge. It holds the acknowledge while the shared bus-busy line shows that another master still owns the bus. Once bus busy is seen low, it drops the acknowledge, drives bus busy itself and tells its device that it is master. The device ends its tenure with a one-cycle done pulse, and the node then releases bus busy.

The asynchronous device request passes through a synchronizer before it is used. The arbitration decision and the data cycles lie outside this block. Several nodes are placed in series by connecting each `grantOut` to the next `grantIn`, and every node watches the same wired-OR bus-busy line.

Top module: `grant_chain_node`

## Requirements
- R1: If the synchronized request is pending on the clock edge where a rising grant is first sampled, the node raises `sackOut` after that same edge and keeps `grantOut` low for the whole grant.
- R2: If no request is pending when a rising grant is first sampled, `grantOut` follows `grantIn` one clock later, both when the grant rises and when it falls.
- R3: When several nodes in a chain request at once, only the requesting node nearest the arbiter raises `sackOut`, and no node further down sees the grant.
- R4: A request that becomes pending while the node is already passing a grant does not interrupt it. `grantOut` stays high until `grantIn` falls, and no acknowledge is raised for that grant.
- R5: While a node holds `sackOut` and samples `bbsyIn` high, it keeps `sackOut` high and leaves `bbsyOut` and `masterOut` low.
- R6: One clock after a selected node samples `bbsyIn` low, `bbsyOut` and `masterOut` are high and `sackOut` is low. `sackOut` and `bbsyOut` are never high together.
- R7: One clock after a master node samples `devDone` high, `bbsyOut` and `masterOut` are low.
- R8: `devReq` passes through a two-flop synchronizer. A request raised only one clock edge before the grant's first sampled edge is not pending for that grant, so the grant is passed on.
- R9: While `rstN` is low, and right after reset is released, `grantOut`, `sackOut`, `bbsyOut` and `masterOut` are all low.

Here "pending" means `devReq` has been seen high on two earlier clock edges. "Rising grant" means `grantIn` is high on an edge after being low on the edge before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | 1 | Asynchronous request from the local device |
| devDone | input | 1 | One-cycle pulse from the local device ending its mastership |
| grantIn | input | 1 | Grant from the upstream neighbour or the arbiter |
| bbsyIn | input | 1 | Shared bus-busy line, wired-OR of all drivers |
| grantOut | output | 1 | Grant passed to the downstream neighbour |
| sackOut | output | 1 | Selection acknowledge toward the arbiter |
| bbsyOut | output | 1 | This node's drive onto the bus-busy line |
| masterOut | output | 1 | Tells the local device that it owns the bus |

## Verification
Every output is a register, so each result is due exactly one clock edge after the input that causes it is sampled. A grant therefore reaches the end of an N-node chain after N edges. A request needs two edges to reach the decision logic. The bench drives and samples on the falling clock edge, so each input gets a full half period to settle. After a new grant, it waits one edge more than the chain length before comparing. For the acknowledge, the mastership handover and the release, it compares after exactly one edge, which confirms that each of these responses lands on its first possible cycle.

// File: rtl/gcn_pkg.sv
package gcn_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PASS   = 2'd1,
    ST_SEL    = 2'd2,
    ST_MASTER = 2'd3
  } nodeState_t;

  // strobes from control to datapath, one per registered output
  typedef struct packed {
    logic passGrant;
    logic driveSack;
    logic driveBusy;
  } nodeStrobe_t;

endpackage

// File: rtl/gcn_datapath.sv
module gcn_datapath
  import gcn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        devReq,
  input  logic        grantIn,
  input  nodeStrobe_t strobe,
  output logic        reqPending,
  output logic        grantRise,
  output logic        grantOut,
  output logic        sackOut,
  output logic        bbsyOut
);

  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] syncChain;
  logic              grantPrev;
  logic              grantOutQ;
  logic              sackQ;
  logic              busyQ;

  // request synchronizer (R8)
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= devReq;
      end
    end else begin : gSyncMany
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_MSB-1:0], devReq};
      end
    end
  endgenerate

  assign reqPending = syncChain[SYNC_MSB];

  // grant edge detector
  always_ff @(posedge clk) begin
    if (!rstN) grantPrev <= 1'b0;
    else       grantPrev <= grantIn;
  end

  assign grantRise = grantIn & ~grantPrev;

  // registered outputs driven by control strobes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantOutQ <= 1'b0;
      sackQ     <= 1'b0;
      busyQ     <= 1'b0;
    end else begin
      grantOutQ <= strobe.passGrant;
      sackQ     <= strobe.driveSack;
      busyQ     <= strobe.driveBusy;
    end
  end

  assign grantOut = grantOutQ;
  assign sackOut  = sackQ;
  assign bbsyOut  = busyQ;

  AST_CAPTURE_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    !(sackOut && grantOut));                                       // R1

  AST_PASS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantOut) |-> $past(grantIn));                           // R2

  AST_PASS_NOT_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (grantOut && grantIn) |=> grantOut);                           // R4

  AST_SACK_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sackOut && bbsyOut));                                        // R6

endmodule

// File: rtl/gcn_control.sv
module gcn_control
  import gcn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPending,
  input  logic        grantRise,
  input  logic        grantIn,
  input  logic        bbsyIn,
  input  logic        devDone,
  output nodeStrobe_t strobe
);

  nodeState_t state;
  nodeState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (grantRise) nextState = reqPending ? ST_SEL : ST_PASS;
      end
      ST_PASS: begin
        // decision is frozen until the grant ends (R4)
        if (!grantIn) nextState = ST_IDLE;
      end
      ST_SEL: begin
        if (!bbsyIn) nextState = ST_MASTER;
      end
      ST_MASTER: begin
        if (devDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.passGrant = (nextState == ST_PASS);
    strobe.driveSack = (nextState == ST_SEL);
    strobe.driveBusy = (nextState == ST_MASTER);
  end

  AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEL && bbsyIn) |=> (state == ST_SEL));            // R5

  AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SEL && !bbsyIn) |=> (state == ST_MASTER));        // R6

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MASTER && devDone) |=> (state == ST_IDLE));       // R7

endmodule

// File: rtl/grant_chain_node.sv
module grant_chain_node
  import gcn_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic devReq,
  input  logic devDone,
  input  logic grantIn,
  input  logic bbsyIn,
  output logic grantOut,
  output logic sackOut,
  output logic bbsyOut,
  output logic masterOut
);

  nodeStrobe_t strobe;
  logic        reqPending;
  logic        grantRise;

  gcn_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .reqPending(reqPending),
    .grantRise (grantRise),
    .grantIn   (grantIn),
    .bbsyIn    (bbsyIn),
    .devDone   (devDone),
    .strobe    (strobe)
  );

  gcn_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .devReq    (devReq),
    .grantIn   (grantIn),
    .strobe    (strobe),
    .reqPending(reqPending),
    .grantRise (grantRise),
    .grantOut  (grantOut),
    .sackOut   (sackOut),
    .bbsyOut   (bbsyOut)
  );

  assign masterOut = bbsyOut;

endmodule

// File: tb/grant_chain_node_bench.sv
module grant_chain_node_bench;

  localparam int NODES = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NODES-1:0] req = '0;
  logic [NODES-1:0] done = '0;
  logic grant0 = 1'b0;
  logic extBusy = 1'b1;
  logic [NODES:0] chain;
  logic [NODES-1:0] sackV, bbsyV, masterV;
  logic busyBus;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign chain[0] = grant0;
  assign busyBus  = extBusy | (|bbsyV);

  for (genvar g = 0; g < NODES; g++) begin : gNode
    if (g == 0) begin : gFirst
      grant_chain_node u_grant_chain_node (
        .clk(clk), .rstN(rstN), .devReq(req[g]), .devDone(done[g]),
        .grantIn(chain[g]), .bbsyIn(busyBus), .grantOut(chain[g+1]),
        .sackOut(sackV[g]), .bbsyOut(bbsyV[g]), .masterOut(masterV[g]));
    end else begin : gRest
      grant_chain_node u_node (
        .clk(clk), .rstN(rstN), .devReq(req[g]), .devDone(done[g]),
        .grantIn(chain[g]), .bbsyIn(busyBus), .grantOut(chain[g+1]),
        .sackOut(sackV[g]), .bbsyOut(bbsyV[g]), .masterOut(masterV[g]));
    end
  end

  // {request mask, expected acknowledge mask}: nearest requester wins
  localparam logic [5:0] VECS [8] = '{
    {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b010, 3'b010}, {3'b011, 3'b001},
    {3'b100, 3'b100}, {3'b101, 3'b001}, {3'b110, 3'b010}, {3'b111, 3'b001}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    waitN(200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] mask, expSack;
    waitN(3);
    // R9: outputs low in reset
    check({chain[NODES:1], sackV, bbsyV, masterV} == '0, "R9 in reset",
          {chain[NODES:1], sackV, bbsyV, masterV}, 0);
    rstN = 1'b1;
    waitN(2);
    check({chain[NODES:1], sackV, bbsyV, masterV} == '0, "R9 after reset",
          {chain[NODES:1], sackV, bbsyV, masterV}, 0);

    for (int i = 0; i < 8; i++) begin
      mask    = VECS[i][5:3];
      expSack = VECS[i][2:0];
      req = mask; extBusy = 1'b1;
      waitN(3);
      grant0 = 1'b1;
      waitN(NODES + 1);
      check(sackV == expSack, "R1/R3 acknowledge", sackV, expSack);
      check(chain[NODES] == (mask == 0), "R2/R3 chain end", chain[NODES], mask == 0);
      check(masterV == 0, "R5 waits on busy", masterV, 0);
      extBusy = 1'b0;
      waitN(1);
      check(masterV == expSack && sackV == 0, "R6 handover",
            {masterV, sackV}, {expSack, 3'b000});
      grant0 = 1'b0; req = '0; done = expSack;
      waitN(1);
      done = '0;
      check(masterV == 0 && bbsyV == 0, "R7 release", {masterV, bbsyV}, 0);
      extBusy = 1'b1;
      waitN(NODES + 1);
      check(chain[NODES:1] == 0, "R2 grant falls", chain[NODES:1], 0);
    end

    // R8: request one edge before grant is not yet pending
    req[0] = 1'b1;
    waitN(1);
    grant0 = 1'b1;
    waitN(1);
    check(chain[1] == 1 && sackV[0] == 0, "R8 late request passes",
          {chain[1], sackV[0]}, 2'b10);
    // R4: grant already passing is not split by the new request
    waitN(NODES + 2);
    check(chain[NODES] == 1 && sackV == 0, "R4 grant kept whole",
          {chain[NODES], sackV}, 4'b1000);
    grant0 = 1'b0;
    waitN(NODES + 1);
    check(chain[NODES:1] == 0, "R2 chain cleared", chain[NODES:1], 0);
    // R1: next grant is captured, one edge later
    grant0 = 1'b1;
    waitN(1);
    check(sackV[0] == 1 && chain[1] == 0, "R1 capture timing",
          {sackV[0], chain[1]}, 2'b10);
    // R5: long wait on busy
    waitN(6);
    check(sackV[0] == 1 && masterV[0] == 0 && bbsyV[0] == 0, "R5 holds acknowledge",
          {sackV[0], masterV[0], bbsyV[0]}, 3'b100);
    extBusy = 1'b0;
    waitN(1);
    check(masterV[0] == 1 && sackV[0] == 0, "R6 takes bus", {masterV[0], sackV[0]}, 2'b10);
    grant0 = 1'b0; req = '0;
    waitN(3);
    check(masterV[0] == 1, "R7 holds until done", masterV[0], 1);
    done[0] = 1'b1;
    waitN(1);
    done[0] = 1'b0;
    check(masterV[0] == 0 && bbsyV[0] == 0, "R7 release on done",
          {masterV[0], bbsyV[0]}, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule